// File: doc/BRIEF.md
# Delayed Read Completion Master

This block sits on the far side of a bus bridge and finishes the read requests that the near side has parked in its delayed-transaction queue. When the request at the head of that queue is eligible, meaning that every posted write queued ahead of it has already gone out, the block asks for the bus. It then replays the read with the same address and command that were captured from the original initiator. Every DWORD the target returns is written into the read-data queue that faces back toward the initiator.

A non-prefetchable read is a single data phase that carries the initiator's own byte enables. A prefetchable read enables every byte lane and bursts one DWORD per clock, with no master wait states, until the next prefetch-boundary-aligned address, unless the target disconnects first. A target retry seen before any data has moved causes the block to reissue the read. A programmable limit bounds those reissues, and when the limit runs out the request is retired with an error and a system-error pulse is raised, provided the error-enable input allows it. A target abort or a master abort retires the request with an error immediately.

Top module: `drc_master`

## Requirements
- R1: No bus request is raised while the write-drained input is low. A read starts only when the queue head is valid and all earlier posted writes are drained.
- R2: One cycle after a sampled grant, the address phase indicator is high for exactly one cycle and presents the queue head's address and 4-bit command unchanged. The data phase indicator is high from the next cycle on.
- R3: For a non-prefetchable request, the active-low byte enables driven during the data phase equal the captured ones. Exactly one DWORD is transferred, and then the entry is popped with the error status low.
- R4: For a prefetchable request, all four active-low byte enables are 0 in every data phase.
- R5: A prefetchable burst that starts at address A moves (B - (A mod B))/4 DWORDs, where B is the boundary in bytes (default 64). Each cycle with DEVSEL and TRDY both high writes that cycle's target data into the read-data queue one cycle later.
- R6: STOP after at least one DWORD has moved ends the request: the entry is popped with the error status low and no further address phase is issued for it.
- R7: STOP with DEVSEL high and TRDY low before any DWORD has moved is a retry. The block requests the bus again and reissues the same address phase.
- R8: When the number of retries for one request reaches the retry limit, the entry is popped with the error status high and no further attempt is made. The system-error output pulses for one cycle, together with the pop, only if error-enable is high.
- R9: STOP with DEVSEL low (target abort), or DEVSEL low for MA_WAIT consecutive data cycles (master abort, default 4), pops the entry with the error status high, makes no further attempt and leaves the system-error output low.
- R10: Data cycles with DEVSEL high and both TRDY and STOP low are wait states. They extend the data phase without loss or duplication of data.
- R11: After reset, the bus request, address phase, data phase, pop, system-error and FIFO write outputs are low, and the byte enables are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid_i | input | 1 | Queue head holds a delayed read |
| q_addr_i | input | AW | Captured read address |
| q_cmd_i | input | 4 | Captured read command |
| q_be_n_i | input | 4 | Captured active-low byte enables |
| q_pref_i | input | 1 | Head request is prefetchable |
| q_pop_o | output | 1 | Retire the head entry (one cycle) |
| q_err_o | output | 1 | Error status that goes with the pop |
| wr_drained_i | input | 1 | All earlier posted writes delivered |
| retry_lim_i | input | CW | Retry count that triggers the error |
| serr_en_i | input | 1 | System-error enable |
| serr_o | output | 1 | System-error pulse |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| addr_valid_o | output | 1 | Address phase indicator |
| addr_o | output | AW | Address driven in the address phase |
| cmd_o | output | 4 | Command driven in the address phase |
| data_act_o | output | 1 | Master in data phase, ready every cycle |
| be_n_o | output | 4 | Active-low byte enables for data phases |
| tgt_devsel_i | input | 1 | Target claimed the cycle (active high) |
| tgt_trdy_i | input | 1 | Target data valid (active high) |
| tgt_stop_i | input | 1 | Target requests termination (active high) |
| tgt_data_i | input | 32 | Read data from the target |
| rdf_we_o | output | 1 | Read-data queue write strobe |
| rdf_data_o | output | 32 | Read-data queue write data |

## Verification
A burst counter that is loaded wrongly or decremented wrongly shows up as a read-data queue that receives too many or too few words. The miscount is visible at the pop, within one boundary span (at most 16 cycles by default). A retry counter that does not clear or compare correctly changes the number of address phases in a retried request, and it moves the error pop and the system-error pulse earlier or later by whole attempts. A lost captured state, such as the prefetch flag or the byte enables, is visible in the first data cycle after the address phase.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_POP
  } drc_state_e;
endpackage

// File: rtl/drc_attempt_ctr.sv
module drc_attempt_ctr #(
  parameter int CW = 33
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] lim,
  output logic          hit
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  assign nxt = {1'b0, cnt_q} + 1'b1;
  assign hit = inc && (nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (inc && !hit) cnt_q <= nxt[CW-1:0];
  end

  AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/drc_burst_ctr.sv
module drc_burst_ctr #(
  parameter int AW        = 32,
  parameter int BND_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          pref,
  input  logic [AW-1:0] addr,
  input  logic          dec,
  output logic          last
);
  localparam int WPB  = BND_BYTES / 4;
  localparam int OFFW = $clog2(BND_BYTES);
  localparam int CNW  = $clog2(WPB) + 1;

  logic [CNW-1:0] cnt_q;
  logic [CNW-1:0] init;

  generate
    if (WPB > 1) begin : g_multi
      assign init = pref ? (CNW'(WPB) - CNW'(addr[OFFW-1:2])) : CNW'(1);
    end else begin : g_single
      assign init = CNW'(1);
    end
  endgenerate

  assign last = (cnt_q == CNW'(1));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= init;
    else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (dec && !load) |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/drc_master.sv
module drc_master
  import drc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CW        = 33,
  parameter int BND_BYTES = 64,
  parameter int MA_WAIT   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          q_valid_i,
  input  logic [AW-1:0] q_addr_i,
  input  logic [3:0]    q_cmd_i,
  input  logic [3:0]    q_be_n_i,
  input  logic          q_pref_i,
  output logic          q_pop_o,
  output logic          q_err_o,
  input  logic          wr_drained_i,
  input  logic [CW-1:0] retry_lim_i,
  input  logic          serr_en_i,
  output logic          serr_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic [3:0]    cmd_o,
  output logic          data_act_o,
  output logic [3:0]    be_n_o,
  input  logic          tgt_devsel_i,
  input  logic          tgt_trdy_i,
  input  logic          tgt_stop_i,
  input  logic [31:0]   tgt_data_i,
  output logic          rdf_we_o,
  output logic [31:0]   rdf_data_o
);
  localparam int MAW = $clog2(MA_WAIT + 1);

  drc_state_e     st_q;
  logic           pref_q;
  logic           got_data_q;
  logic [MAW-1:0] ma_cnt_q;

  logic in_data, xfer, t_abort, m_abort, retry, end_ok, lim_hit, blast, start;

  assign in_data = (st_q == ST_DATA);
  assign xfer    = in_data && tgt_devsel_i && tgt_trdy_i;
  assign t_abort = in_data && tgt_stop_i && !tgt_devsel_i;
  assign m_abort = in_data && !tgt_devsel_i && !tgt_stop_i &&
                   (ma_cnt_q == MAW'(MA_WAIT - 1));
  assign retry   = in_data && tgt_devsel_i && tgt_stop_i && !tgt_trdy_i && !got_data_q;
  assign end_ok  = (xfer && (tgt_stop_i || blast)) ||
                   (in_data && tgt_devsel_i && tgt_stop_i && !tgt_trdy_i && got_data_q);
  assign start   = (st_q == ST_IDLE) && q_valid_i && wr_drained_i;

  drc_attempt_ctr #(.CW(CW)) u_attempts (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .inc (retry),
    .lim (retry_lim_i),
    .hit (lim_hit)
  );

  drc_burst_ctr #(.AW(AW), .BND_BYTES(BND_BYTES)) u_burst (
    .clk  (clk),
    .rst  (rst),
    .load (st_q == ST_ADDR),
    .pref (pref_q),
    .addr (addr_o),
    .dec  (xfer),
    .last (blast)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      pref_q       <= 1'b0;
      got_data_q   <= 1'b0;
      ma_cnt_q     <= '0;
      bus_req_o    <= 1'b0;
      addr_valid_o <= 1'b0;
      addr_o       <= '0;
      cmd_o        <= '0;
      data_act_o   <= 1'b0;
      be_n_o       <= 4'hF;
      q_pop_o      <= 1'b0;
      q_err_o      <= 1'b0;
      serr_o       <= 1'b0;
      rdf_we_o     <= 1'b0;
      rdf_data_o   <= '0;
    end else begin
      q_pop_o  <= 1'b0;
      serr_o   <= 1'b0;
      rdf_we_o <= xfer;
      if (xfer) rdf_data_o <= tgt_data_i;
      case (st_q)
        ST_IDLE: if (start) begin
          st_q      <= ST_REQ;
          bus_req_o <= 1'b1;
        end
        ST_REQ: if (bus_gnt_i) begin
          st_q         <= ST_ADDR;
          bus_req_o    <= 1'b0;
          addr_valid_o <= 1'b1;
          addr_o       <= q_addr_i;
          cmd_o        <= q_cmd_i;
          pref_q       <= q_pref_i;
        end
        ST_ADDR: begin
          st_q         <= ST_DATA;
          addr_valid_o <= 1'b0;
          data_act_o   <= 1'b1;
          be_n_o       <= pref_q ? 4'h0 : q_be_n_i;
          got_data_q   <= 1'b0;
          ma_cnt_q     <= '0;
        end
        ST_DATA: begin
          if (xfer) got_data_q <= 1'b1;
          ma_cnt_q <= tgt_devsel_i ? '0 : ma_cnt_q + 1'b1;
          if (end_ok || t_abort || m_abort || (retry && lim_hit)) begin
            st_q       <= ST_POP;
            data_act_o <= 1'b0;
            be_n_o     <= 4'hF;
            q_pop_o    <= 1'b1;
            q_err_o    <= !end_ok;
            serr_o     <= retry && lim_hit && serr_en_i;
          end else if (retry) begin
            st_q       <= ST_REQ;
            data_act_o <= 1'b0;
            be_n_o     <= 4'hF;
            bus_req_o  <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_IDLE) && !wr_drained_i) |=> !bus_req_o); // R1
  AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    addr_valid_o |=> (!addr_valid_o && data_act_o)); // R2
  AST_PREF_ALL_BE: assert property (@(posedge clk) disable iff (rst)
    (data_act_o && pref_q) |-> (be_n_o == 4'h0)); // R4
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (rst)
    q_pop_o |=> (!q_pop_o && !data_act_o && !bus_req_o)); // R6
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
    serr_o |-> ($past(serr_en_i) && q_pop_o && q_err_o)); // R8
  AST_FIFO_WRITE: assert property (@(posedge clk) disable iff (rst)
    rdf_we_o |-> $past(data_act_o)); // R5
endmodule

// File: tb/drc_master_bench.sv
module drc_master_bench;
  localparam int AW = 32;
  localparam int CW = 33;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          q_valid, q_pref, wr_drained, serr_en, bus_gnt;
  logic [AW-1:0] q_addr;
  logic [3:0]    q_cmd, q_be_n;
  logic [CW-1:0] retry_lim;
  logic          devsel, trdy, stop;
  logic [31:0]   tdata;
  logic          q_pop, q_err, serr, bus_req, addr_valid, data_act, rdf_we;
  logic [AW-1:0] addr_out;
  logic [3:0]    cmd_out, be_n_out;
  logic [31:0]   rdf_data;

  drc_master u_drc_master (
    .clk(clk), .rst(rst),
    .q_valid_i(q_valid), .q_addr_i(q_addr), .q_cmd_i(q_cmd), .q_be_n_i(q_be_n),
    .q_pref_i(q_pref), .q_pop_o(q_pop), .q_err_o(q_err),
    .wr_drained_i(wr_drained), .retry_lim_i(retry_lim), .serr_en_i(serr_en),
    .serr_o(serr), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .addr_valid_o(addr_valid), .addr_o(addr_out), .cmd_o(cmd_out),
    .data_act_o(data_act), .be_n_o(be_n_out),
    .tgt_devsel_i(devsel), .tgt_trdy_i(trdy), .tgt_stop_i(stop), .tgt_data_i(tdata),
    .rdf_we_o(rdf_we), .rdf_data_o(rdf_data)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // target script: retries before accepting, disconnect word, wait states, abort kind
  int t_retries = 0, t_disc = 0, t_wait = 0, t_abort = 0;
  int t_att = 0, t_cyc = 0, t_words = 0;
  logic [AW-1:0] t_base;

  function automatic logic [31:0] pattern(input logic [AW-1:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // grant and target model, driven away from the active edge
  always @(negedge clk) begin
    bus_gnt = bus_req;
    devsel = 1'b0; trdy = 1'b0; stop = 1'b0; tdata = '0;
    if (rst || q_pop) begin
      t_att = 0; t_words = 0;
    end
    if (addr_valid) begin
      t_att++; t_cyc = 0; t_base = addr_out;
    end else if (data_act) begin
      if (t_abort == 1) begin
        stop = 1'b1;
      end else if (t_abort == 2) begin
        devsel = 1'b0;
      end else if (t_att <= t_retries) begin
        devsel = 1'b1; stop = 1'b1;
      end else if (t_cyc < t_wait) begin
        devsel = 1'b1;
      end else begin
        devsel = 1'b1; trdy = 1'b1;
        tdata = pattern(t_base + AW'(4 * t_words));
        t_words++;
        stop = (t_disc != 0) && (t_words == t_disc);
      end
      t_cyc++;
    end
  end

  // runs one queued request to its pop and compares with computed expectations
  task automatic run_req(input logic [AW-1:0] a, input logic pref, input logic [3:0] be,
                         input int lim, input logic sen, input string tag);
    int n_addr = 0, n_words = 0, n_serr = 0, be_bad = 0, addr_bad = 0, data_bad = 0;
    int exp_words, exp_addr, len, tmo = 0;
    logic got_err = 1'b0, done = 1'b0;
    logic exp_err;
    q_addr = a; q_pref = pref; q_be_n = be; q_cmd = 4'h6 + {3'b0, pref};
    retry_lim = CW'(lim); serr_en = sen; q_valid = 1'b1;
    while (!done) begin
      @(negedge clk);
      tmo++;
      if (addr_valid && (addr_out != a || cmd_out != q_cmd)) addr_bad++;
      if (addr_valid) n_addr++;
      if (data_act && be_n_out != (pref ? 4'h0 : be)) be_bad++;
      if (rdf_we) begin
        if (rdf_data != pattern(a + AW'(4 * n_words))) data_bad++;
        n_words++;
      end
      if (serr) n_serr++;
      if (q_pop) begin got_err = q_err; done = 1'b1; end
      if (tmo > 2000) begin
        check(0, {tag, " timeout"}, tmo, 0);
        done = 1'b1;
      end
    end
    q_valid = 1'b0;
    len = pref ? (64 - int'(a % 64)) / 4 : 1;
    if (t_disc != 0 && t_disc < len) len = t_disc;
    if (t_abort != 0) begin
      exp_words = 0; exp_addr = 1; exp_err = 1'b1;
    end else if (t_retries >= lim) begin
      exp_words = 0; exp_addr = lim; exp_err = 1'b1;
    end else begin
      exp_words = len; exp_addr = t_retries + 1; exp_err = 1'b0;
    end
    check(n_words == exp_words, {tag, " words"}, n_words, exp_words);
    check(n_addr == exp_addr, {tag, " addr phases"}, n_addr, exp_addr);
    check(got_err == exp_err, {tag, " pop status"}, got_err, exp_err);
    check(n_serr == ((exp_err && t_abort == 0 && sen) ? 1 : 0), {tag, " serr"}, n_serr,
          (exp_err && t_abort == 0 && sen) ? 1 : 0);
    check(be_bad == 0, {tag, " byte enables"}, be_bad, 0);
    check(addr_bad == 0 && data_bad == 0, {tag, " addr/data"}, addr_bad + data_bad, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    q_valid = 0; q_pref = 0; q_addr = '0; q_cmd = '0; q_be_n = '0;
    wr_drained = 1'b1; serr_en = 1'b0; retry_lim = CW'(3);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R11: reset state
    check(!bus_req && !addr_valid && !data_act && !q_pop && !serr && !rdf_we,
          "R11 outputs idle", {bus_req, addr_valid, data_act, q_pop, serr, rdf_we}, 0);
    check(be_n_out == 4'hF, "R11 byte enables", be_n_out, 15);

    // R1: no request while posted writes are pending
    begin
      int seen = 0;
      wr_drained = 1'b0; q_valid = 1'b1; q_pref = 1'b0; q_addr = 32'h100;
      repeat (12) begin @(negedge clk); if (bus_req) seen++; end
      check(seen == 0, "R1 gated by drained", seen, 0);
      q_valid = 1'b0; wr_drained = 1'b1;
      @(negedge clk);
    end

    // R3: non-prefetchable sweep over every byte-enable pattern
    for (int b = 0; b < 16; b++)
      run_req(32'h0000_2000 + 32'(b * 4), 1'b0, 4'(b), 3, 1'b1, "R3 R2 nonpref");

    // R4 R5: prefetchable sweep over every start offset within the boundary
    for (int o = 0; o < 64; o += 4)
      run_req(32'h0001_0000 + 32'(o), 1'b1, 4'hA, 3, 1'b1, "R4 R5 pref burst");

    // R6: disconnect after data, at several word counts
    for (int d = 1; d < 5; d++) begin
      t_disc = d;
      run_req(32'h0002_0000, 1'b1, 4'h0, 3, 1'b1, "R6 disconnect");
    end
    t_disc = 0;

    // R10: target wait states
    for (int w = 1; w < 4; w++) begin
      t_wait = w;
      run_req(32'h0003_0030, 1'b1, 4'h0, 3, 1'b0, "R10 wait states");
    end
    t_wait = 0;

    // R7 R8: retry counts around the limit, with and without error enable
    for (int lim = 1; lim < 4; lim++)
      for (int r = 0; r <= lim + 1; r++)
        for (int e = 0; e < 2; e++) begin
          t_retries = r;
          run_req(32'h0004_0020, 1'b1, 4'h0, lim, e[0], "R7 R8 retry limit");
        end
    t_retries = 0;

    // R9: target abort and master abort
    for (int k = 1; k < 3; k++)
      for (int e = 0; e < 2; e++) begin
        t_abort = k;
        run_req(32'h0005_0000, e[0], 4'h3, 3, 1'b1, "R9 abort");
      end
    t_abort = 0;

    finish_run();
  end
endmodule